// File: doc/BRIEF.md
# Serial Register-Access Slave Port

This block lets an external controller read and write a small bank of configuration registers over a four-wire serial bus. The bus has an active-low select, a serial clock, a data input and a data output with a separate drive enable. The serial wires are brought into the system clock domain through two-flop synchronizers. A frame-level state machine decodes each frame as it arrives and drives the register bank.

A frame opens with a 7-bit device identifier followed by a direction bit. A write frame then carries a pointer byte, followed by any number of data bytes. A read runs as two frames. The first is a write frame that stops right after the pointer byte. The second is a read frame that streams register contents starting at that pointer. The pointer byte also holds an increment flag that allows block transfers. Register 0 holds a port-enable flag. While that flag is set, the effective mode comes from register 1 instead of the external configuration inputs.

The state machine has six states:
- IDLE: waiting for select to fall.
- HEADER: receiving the identifier and the direction bit.
- POINTER: receiving the pointer byte.
- WRITE_DATA: receiving data bytes.
- READ_DATA: driving data bytes out.
- SKIP: a foreign frame, ignored until select rises.

It has these transitions:
- IDLE to HEADER when select falls.
- HEADER to SKIP when the identifier does not match.
- HEADER to POINTER on a matching write.
- HEADER to READ_DATA on a matching read.
- POINTER to WRITE_DATA after eight bits.
- Any state to IDLE when select rises.

Top module: `spi_regport_top`

## Requirements
- R1: Input bits are captured on rising serial-clock edges and output bits change only on falling edges. All bytes travel MSB first.
- R2: The first seven bits of a frame must equal 1001111 for the frame to be accepted. The eighth bit selects the direction: 0 is write, 1 is read. As a header byte, a write is 0x9E and a read is 0x9F.
- R3: In a write frame, the byte after the header loads the pointer. Each further complete byte is written to the register the pointer selects.
- R4: The data-output enable stays low for the whole of every write frame.
- R5: In the pointer byte, bit 7 is the increment flag and bits 6:0 are the register address. With the flag at 0, every data byte of the frame, read or written, uses the same address. With the flag at 1, the address advances by one after each byte.
- R6: A write frame that ends after the pointer byte changes no register. In the following read frame, the output enable rises at the falling edge right after the direction bit, and the bytes returned are the registers starting at the pointer.
- R7: A frame whose identifier does not match writes nothing and keeps the output enable low until select rises.
- R8: Select rising at any point aborts the frame. A partly received data byte is discarded and not written, and the next frame decodes from its first bit.
- R9: The bank has 16 registers at addresses 0 to 15. Reads of addresses 16 to 127 return 0, and writes to those addresses change no register.
- R10: Bit 7 of register 0 is the port-enable flag, brought out as `port_en`. While it is 0, `mode_eff` follows `cfg_pins`. While it is 1, `mode_eff` equals register 1 and `cfg_pins` has no effect.
- R11: After reset, all registers read 0, the output enable is low and `mode_eff` follows `cfg_pins`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial bit clock from the controller |
| ser_sel_n | input | 1 | Active-low frame select |
| ser_din | input | 1 | Serial data from the controller |
| ser_dout | output | 1 | Serial data to the controller |
| ser_dout_en | output | 1 | Drive enable for ser_dout (low means high impedance) |
| cfg_pins | input | 8 | External mode configuration inputs |
| port_en | output | 1 | Port-enable flag from register 0 bit 7 |
| mode_eff | output | 8 | Effective operating mode |

## Verification
The bench goes after the read hand-off first. If the output were enabled or loaded one edge late, the MSB would be lost and every read byte would come back shifted by a bit. It also covers increment on and off, in both directions. A design that advanced the pointer when the flag is clear would spread a burst across neighbouring registers. A design that ignored the flag on reads would repeat or skip registers. Aborted frames, a bad identifier and addresses past the bank are each probed through a later read. These catch a design that commits half a byte, acts on a foreign frame, or aliases high addresses onto low registers. The enable flag is toggled while `cfg_pins` moves, which exposes a reversed or stuck mode select.

// File: rtl/spi_regport_pkg.sv
package spi_regport_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HEADER,
        ST_POINTER,
        ST_WRITE_DATA,
        ST_READ_DATA,
        ST_SKIP
    } frame_st_e;

endpackage

// File: rtl/spi_regport_sync.sv
module spi_regport_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ser_clk,
    input  logic ser_sel_n,
    input  logic ser_din,
    output logic clk_rise,
    output logic clk_fall,
    output logic sel_fall,
    output logic sel_rise,
    output logic din_s
);
    logic [STAGES-1:0] clk_ff, sel_ff, din_ff;
    logic              clk_last, sel_last;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    clk_ff <= '0;
                    sel_ff <= '1;
                    din_ff <= '0;
                end else begin
                    clk_ff <= ser_clk;
                    sel_ff <= ser_sel_n;
                    din_ff <= ser_din;
                end
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    clk_ff <= '0;
                    sel_ff <= '1;
                    din_ff <= '0;
                end else begin
                    clk_ff <= {clk_ff[STAGES-2:0], ser_clk};
                    sel_ff <= {sel_ff[STAGES-2:0], ser_sel_n};
                    din_ff <= {din_ff[STAGES-2:0], ser_din};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clk_last <= 1'b0;
            sel_last <= 1'b1;
        end else begin
            clk_last <= clk_ff[STAGES-1];
            sel_last <= sel_ff[STAGES-1];
        end
    end

    assign clk_rise = clk_ff[STAGES-1] & ~clk_last;
    assign clk_fall = ~clk_ff[STAGES-1] & clk_last;
    assign sel_fall = ~sel_ff[STAGES-1] & sel_last;
    assign sel_rise = sel_ff[STAGES-1] & ~sel_last;
    assign din_s    = din_ff[STAGES-1];
endmodule

// File: rtl/spi_regport_frame.sv
module spi_regport_frame
    import spi_regport_pkg::*;
#(
    parameter int          DW     = 8,
    parameter int          AW     = 7,
    parameter int          IDW    = 7,
    parameter logic [IDW-1:0] DEV_ID = 7'b1001111
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clk_rise,
    input  logic          clk_fall,
    input  logic          sel_fall,
    input  logic          sel_rise,
    input  logic          din_s,
    input  logic [DW-1:0] rd_data,
    output logic [AW-1:0] rd_addr,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic          dout,
    output logic          dout_en,
    output frame_st_e     state
);
    localparam int CW = $clog2(DW);
    localparam logic [CW-1:0] LAST = CW'(DW - 1);

    frame_st_e     state_nx;
    logic [CW-1:0] in_cnt, out_cnt;
    logic [DW-2:0] sh_in;
    logic [DW-1:0] sh_out;
    logic [AW-1:0] ptr;
    logic          incr;
    logic          byte_done;
    logic          id_ok;

    assign byte_done = clk_rise && (in_cnt == LAST);
    assign id_ok     = (sh_in[IDW-1:0] == DEV_ID);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        if (sel_rise) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:       if (sel_fall) state_nx = ST_HEADER;
                ST_HEADER:     if (byte_done) begin
                                   if (!id_ok)     state_nx = ST_SKIP;
                                   else if (din_s) state_nx = ST_READ_DATA;
                                   else            state_nx = ST_POINTER;
                               end
                ST_POINTER:    if (byte_done) state_nx = ST_WRITE_DATA;
                ST_WRITE_DATA: state_nx = ST_WRITE_DATA;
                ST_READ_DATA:  state_nx = ST_READ_DATA;
                ST_SKIP:       state_nx = ST_SKIP;
                default:       state_nx = ST_IDLE;
            endcase
        end
    end

    assign rd_addr = (state == ST_READ_DATA && out_cnt == LAST && incr) ? ptr + 1'b1 : ptr;

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_cnt  <= '0;
            out_cnt <= '0;
            sh_in   <= '0;
            sh_out  <= '0;
            ptr     <= '0;
            incr    <= 1'b0;
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
            dout    <= 1'b0;
            dout_en <= 1'b0;
        end else begin
            wr_en <= 1'b0;
            if (sel_rise || state == ST_IDLE) begin
                in_cnt  <= '0;
                out_cnt <= '0;
                dout_en <= 1'b0;
            end else begin
                if (clk_rise) begin
                    sh_in  <= {sh_in[DW-3:0], din_s};
                    in_cnt <= in_cnt + 1'b1;
                    if (in_cnt == LAST) begin
                        unique case (state)
                            ST_HEADER: if (id_ok && din_s) begin
                                sh_out  <= rd_data;
                                out_cnt <= '0;
                            end
                            ST_POINTER: begin
                                incr <= sh_in[DW-2];
                                ptr  <= {sh_in[AW-2:0], din_s};
                            end
                            ST_WRITE_DATA: begin
                                wr_en   <= 1'b1;
                                wr_addr <= ptr;
                                wr_data <= {sh_in, din_s};
                                if (incr) ptr <= ptr + 1'b1;
                            end
                            default: ;
                        endcase
                    end
                end
                if (clk_fall && state == ST_READ_DATA) begin
                    dout    <= sh_out[DW-1];
                    dout_en <= 1'b1;
                    out_cnt <= out_cnt + 1'b1;
                    if (out_cnt == LAST) begin
                        sh_out <= rd_data;
                        ptr    <= rd_addr;
                    end else begin
                        sh_out <= {sh_out[DW-2:0], 1'b0};
                    end
                end
            end
        end
    end
endmodule

// File: rtl/spi_regport_bank.sv
module spi_regport_bank #(
    parameter int NREGS  = 16,
    parameter int DW     = 8,
    parameter int AW     = 7,
    parameter int EN_BIT = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    output logic          port_en,
    output logic [DW-1:0] mode_reg
);
    localparam int IW = $clog2(NREGS);

    logic [DW-1:0] regs [NREGS];

    genvar gi;
    generate
        for (gi = 0; gi < NREGS; gi++) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                                 regs[gi] <= '0;
                else if (wr_en && wr_addr == AW'(gi))       regs[gi] <= wr_data;
            end
        end
    endgenerate

    assign rd_data  = (rd_addr < AW'(NREGS)) ? regs[rd_addr[IW-1:0]] : '0;
    assign port_en  = regs[0][EN_BIT];
    assign mode_reg = regs[1];
endmodule

// File: rtl/spi_regport_top.sv
module spi_regport_top
    import spi_regport_pkg::*;
#(
    parameter int DW     = 8,
    parameter int AW     = 7,
    parameter int NREGS  = 16,
    parameter int STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ser_clk,
    input  logic          ser_sel_n,
    input  logic          ser_din,
    output logic          ser_dout,
    output logic          ser_dout_en,
    input  logic [DW-1:0] cfg_pins,
    output logic          port_en,
    output logic [DW-1:0] mode_eff
);
    logic          clk_rise, clk_fall, sel_fall, sel_rise, din_s;
    logic [DW-1:0] rd_data, wr_data, mode_reg;
    logic [AW-1:0] rd_addr, wr_addr;
    logic          wr_en;
    frame_st_e     state;

    spi_regport_sync #(.STAGES(STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .ser_clk(ser_clk), .ser_sel_n(ser_sel_n), .ser_din(ser_din),
        .clk_rise(clk_rise), .clk_fall(clk_fall),
        .sel_fall(sel_fall), .sel_rise(sel_rise), .din_s(din_s)
    );

    spi_regport_frame #(.DW(DW), .AW(AW)) u_frame (
        .clk(clk), .rst_n(rst_n),
        .clk_rise(clk_rise), .clk_fall(clk_fall),
        .sel_fall(sel_fall), .sel_rise(sel_rise), .din_s(din_s),
        .rd_data(rd_data), .rd_addr(rd_addr),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .dout(ser_dout), .dout_en(ser_dout_en), .state(state)
    );

    spi_regport_bank #(.NREGS(NREGS), .DW(DW), .AW(AW), .EN_BIT(DW-1)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .port_en(port_en), .mode_reg(mode_reg)
    );

    assign mode_eff = port_en ? mode_reg : cfg_pins;
endmodule

// File: rtl/spi_regport_chk.sv
module spi_regport_chk
    import spi_regport_pkg::*;
#(
    parameter int DW    = 8,
    parameter int AW    = 7,
    parameter int NREGS = 16
) (
    input logic          clk,
    input logic          rst_n,
    input frame_st_e     state,
    input logic          ser_dout,
    input logic          ser_dout_en,
    input logic          clk_fall,
    input logic          wr_en,
    input logic [AW-1:0] rd_addr,
    input logic [DW-1:0] rd_data,
    input logic          port_en,
    input logic [DW-1:0] mode_reg,
    input logic [DW-1:0] mode_eff
);
    // R1: data out moves only after a falling serial edge
    p_dout_on_fall_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_fall |=> $stable(ser_dout));

    // R4: no drive during any write-frame state
    p_quiet_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_POINTER || state == ST_WRITE_DATA) |-> !ser_dout_en);

    // R6: drive only inside a read frame
    p_drive_in_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ser_dout_en |-> state == ST_READ_DATA);

    // R7: foreign frame never drives nor writes
    p_skip_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_SKIP |-> (!ser_dout_en && !wr_en));

    // R8: writes are issued only from the data phase of a live frame
    p_write_in_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(state) == ST_WRITE_DATA);

    // R9: unimplemented addresses read as zero
    p_unimpl_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr >= AW'(NREGS)) |-> rd_data == '0);

    // R10: enabled port drives mode from register 1
    p_mode_sel_r10: assert property (@(posedge clk) disable iff (!rst_n)
        port_en |-> mode_eff == mode_reg);
endmodule

bind spi_regport_top spi_regport_chk #(.DW(DW), .AW(AW), .NREGS(NREGS)) u_chk (
    .clk(clk), .rst_n(rst_n), .state(state),
    .ser_dout(ser_dout), .ser_dout_en(ser_dout_en), .clk_fall(clk_fall),
    .wr_en(wr_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .port_en(port_en), .mode_reg(mode_reg), .mode_eff(mode_eff)
);

// File: tb/spi_regport_tb.sv
module spi_regport_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 6;
    localparam logic [7:0] HDR_WR = 8'h9E;
    localparam logic [7:0] HDR_RD = 8'h9F;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_clk = 1'b0, ser_sel_n = 1'b1, ser_din = 1'b0;
    logic       ser_dout, ser_dout_en, port_en;
    logic [7:0] cfg_pins = 8'h5A;
    logic [7:0] mode_eff;

    int checks = 0;
    int errors = 0;
    logic oe_any, oe_all;
    logic [7:0] rdq [4];

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_regport_top dut_i (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_sel_n(ser_sel_n),
        .ser_din(ser_din), .ser_dout(ser_dout), .ser_dout_en(ser_dout_en),
        .cfg_pins(cfg_pins), .port_en(port_en), .mode_eff(mode_eff)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic open_frame();
        ser_sel_n = 1'b0;
        oe_any = 1'b0;
        wait_clk(4);
    endtask

    task automatic close_frame();
        wait_clk(4);
        ser_sel_n = 1'b1;
        wait_clk(8);
    endtask

    task automatic xfer_bits(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
        rx = '0;
        oe_all = 1'b1;
        for (int i = 7; i > 7 - nbits; i--) begin
            ser_din = tx[i];
            wait_clk(HALF);
            rx[i] = ser_dout;
            oe_any |= ser_dout_en;
            oe_all &= ser_dout_en;
            ser_clk = 1'b1;
            oe_any |= ser_dout_en;
            wait_clk(HALF);
            ser_clk = 1'b0;
        end
    endtask

    task automatic wr_frame(input logic [7:0] hdr, input logic [7:0] ptr, input int n,
                            input logic [7:0] d0, input logic [7:0] d1, input logic [7:0] d2);
        logic [7:0] rx;
        logic [7:0] d [3];
        d = '{d0, d1, d2};
        open_frame();
        xfer_bits(hdr, 8, rx);
        xfer_bits(ptr, 8, rx);
        for (int k = 0; k < n; k++) xfer_bits(d[k], 8, rx);
        close_frame();
    endtask

    task automatic rd_frame(input logic [7:0] hdr, input int n, output logic first_oe);
        logic [7:0] rx;
        open_frame();
        xfer_bits(hdr, 8, rx);
        first_oe = 1'b0;
        for (int k = 0; k < n; k++) begin
            xfer_bits(8'h00, 8, rx);
            if (k == 0) first_oe = oe_all;
            rdq[k] = rx;
        end
        close_frame();
    endtask

    task automatic read_regs(input logic [7:0] ptr, input int n, output logic first_oe);
        wr_frame(HDR_WR, ptr, 0, 0, 0, 0);
        rd_frame(HDR_RD, n, first_oe);
    endtask

    task automatic t_reset();
        logic f;
        check("R11 dout_en after reset", ser_dout_en, 0);
        check("R11 port_en after reset", port_en, 0);
        check("R11 mode follows cfg", mode_eff, 8'h5A);
        read_regs(8'h85, 2, f);
        check("R11 reg5 zero", rdq[0], 0);
        check("R11 reg6 zero", rdq[1], 0);
        check("R11 dout_en low after frame", ser_dout_en, 0);
    endtask

    task automatic t_single();
        logic f;
        wr_frame(HDR_WR, 8'h02, 1, 8'hA5, 0, 0);
        check("R4 no drive during write", oe_any, 0);
        read_regs(8'h02, 1, f);
        check("R6 enable from first data bit", f, 1);
        check("R3 R1 R2 readback reg2", rdq[0], 8'hA5);
        check("R6 release after frame", ser_dout_en, 0);
    endtask

    task automatic t_block_incr();
        logic f;
        wr_frame(HDR_WR, 8'h83, 3, 8'h11, 8'h22, 8'h33);
        read_regs(8'h83, 3, f);
        check("R5 incr reg3", rdq[0], 8'h11);
        check("R5 incr reg4", rdq[1], 8'h22);
        check("R5 incr reg5", rdq[2], 8'h33);
    endtask

    task automatic t_no_incr();
        logic f;
        wr_frame(HDR_WR, 8'h06, 2, 8'h12, 8'h34, 0);
        read_regs(8'h06, 2, f);
        check("R5 fixed ptr last write wins", rdq[0], 8'h34);
        check("R5 fixed ptr read repeats", rdq[1], 8'h34);
        read_regs(8'h07, 1, f);
        check("R5 neighbour untouched", rdq[0], 8'h00);
    endtask

    task automatic t_bad_id();
        logic f;
        wr_frame(8'h9C, 8'h02, 1, 8'hFF, 0, 0);
        check("R7 no drive on foreign write", oe_any, 0);
        rd_frame(8'h9D, 1, f);
        check("R7 no drive on foreign read", oe_any, 0);
        read_regs(8'h02, 1, f);
        check("R7 reg2 unchanged", rdq[0], 8'hA5);
    endtask

    task automatic t_abort();
        logic [7:0] rx;
        logic f;
        open_frame();
        xfer_bits(HDR_WR, 8, rx);
        xfer_bits(8'h08, 8, rx);
        xfer_bits(8'hFF, 5, rx);
        close_frame();
        open_frame();
        xfer_bits(HDR_WR, 3, rx);
        close_frame();
        read_regs(8'h08, 1, f);
        check("R8 partial byte discarded", rdq[0], 8'h00);
    endtask

    task automatic t_ptr_only();
        logic f;
        wr_frame(HDR_WR, 8'h03, 0, 0, 0, 0);
        wr_frame(HDR_WR, 8'h04, 0, 0, 0, 0);
        read_regs(8'h03, 1, f);
        check("R6 pointer frame writes nothing", rdq[0], 8'h11);
    endtask

    task automatic t_unimpl();
        logic f;
        wr_frame(HDR_WR, 8'h20, 1, 8'h77, 0, 0);
        read_regs(8'h20, 1, f);
        check("R9 high addr reads zero", rdq[0], 0);
        read_regs(8'h00, 1, f);
        check("R9 no alias into reg0", rdq[0], 0);
        read_regs(8'h8F, 2, f);
        check("R9 reg15 then past end", rdq[1], 0);
    endtask

    task automatic t_port_en();
        wr_frame(HDR_WR, 8'h01, 1, 8'hC3, 0, 0);
        check("R10 disabled follows cfg", mode_eff, 8'h5A);
        wr_frame(HDR_WR, 8'h00, 1, 8'h80, 0, 0);
        check("R10 enable flag set", port_en, 1);
        check("R10 mode from reg1", mode_eff, 8'hC3);
        cfg_pins = 8'h0F;
        wait_clk(2);
        check("R10 cfg ignored when enabled", mode_eff, 8'hC3);
        wr_frame(HDR_WR, 8'h00, 1, 8'h00, 0, 0);
        check("R10 back to cfg", mode_eff, 8'h0F);
    endtask

    initial begin
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);
        t_reset();
        t_single();
        t_block_incr();
        t_no_incr();
        t_bad_id();
        t_abort();
        t_ptr_only();
        t_unimpl();
        t_port_en();
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end
endmodule